// File: doc/BRIEF.md
# Cross-Domain Watchdog Register Interface

This block is a watchdog timer whose down-counter lives in its own clock domain, unrelated to the clock of the register bus that software uses to program it. Software writes a control word, a load value, or an interrupt-clear strobe over a simple register bus. Each write is carried into the counter domain by a toggle handshake with two-flop synchronisers in both directions. A write-complete flag in the control word goes low on every accepted write. It goes high again only once the counter domain has applied the write and its acknowledge has come back. Software polls that flag before its next write, or before a read that must see the effect of the write.

Once enabled, the counter counts down from the load value. When it first reaches zero it raises an interrupt and reloads. If it reaches zero again while the interrupt is still pending and the reset-enable bit is set, it raises a sticky reset request. Reads never touch the moving counter. They return bus-side copies of the written fields and a snapshot of the count and pending flag. The counter domain pushes that snapshot across through a second toggle handshake, both after each applied write and periodically.

Top module: `xdom_wdog`

## Requirements
- R1: After reset the control word (address 0) reads 0x8000_0000: write-complete (bit 31) is 1, the error flag (bit 30), interrupt-enable (bit 0), reset-enable (bit 1) and pending (bit 2) are 0, and `wd_irq` and `wd_rst_req` are low.
- R2: A write accepted while write-complete is 1 clears write-complete from the next bus cycle on.
- R3: Write-complete returns to 1 within a bounded number of bus cycles, once the write has been applied in the counter domain and acknowledged back.
- R4: A write issued while write-complete is 0 changes no register and sets the error flag (bit 30). The next accepted write clears the error flag.
- R5: A read at address 0 (control), 1 (load), 2 (value) or 3 (reads zero) returns its data on `bus_rdata` one bus cycle after `bus_rd_en`. Reads may be issued on consecutive cycles regardless of write-complete.
- R6: After reset the counter holds its value (the reset load 0xFFFF) and `wd_irq` stays low until a control write sets interrupt-enable (bit 0).
- R7: With interrupt-enable and reset-enable set, the first expiry sets pending (`wd_irq`) and reloads. `wd_rst_req` rises exactly load+1 counter-clock cycles after `wd_irq` rose and then stays high until the counter-domain reset.
- R8: With reset-enable clear, repeated expiries keep `wd_irq` high and never raise `wd_rst_req`.
- R9: A write to address 3 clears the pending interrupt and reloads the counter, so clearing once per period prevents a reset request.
- R10: Address 2 returns a snapshot of the count that never exceeds the load value, and bit 2 of the control word shows the pending interrupt once a snapshot has crossed over.
- R11: A write to address 1 sets the load value and reloads the counter even while counting is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| wd_clk | input | 1 | Counter-domain clock |
| wd_rst_n | input | 1 | Counter-domain asynchronous reset, active low |
| wd_irq | output | 1 | Timeout interrupt (pending flag) |
| wd_rst_req | output | 1 | Sticky reset request |

## Verification
The assertions assume that the bus-side hold registers stay unchanged while a write is in flight, and that the counter-domain snapshot stays unchanged until the bus side acknowledges it. Both conditions come from the blocking rule on write-complete and from the snapshot handshake. They also assume that the two resets are released while no write is pending. The stimulus keeps to this by polling write-complete after every write, apart from the one deliberate back-to-back write that checks the blocking rule. It asserts both resets together and drives bus inputs only on falling bus-clock edges.

// File: rtl/xwd_pkg.sv
package xwd_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ADR_CTRL  = 2'd0,
        ADR_LOAD  = 2'd1,
        ADR_VALUE = 2'd2,
        ADR_ICLR  = 2'd3
    } wd_addr_e;

    localparam int CTL_IE_BIT   = 0;
    localparam int CTL_RE_BIT   = 1;
    localparam int CTL_PEND_BIT = 2;
    localparam int CTL_ERR_BIT  = 30;
    localparam int CTL_WC_BIT   = 31;

endpackage

// File: rtl/wd_sync2.sv
module wd_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/wd_bus_if.sv
module wd_bus_if
    import xwd_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RESET_LOAD = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              req_tog,
    output logic [1:0]        hold_addr,
    output logic [CNT_W-1:0]  hold_data,
    input  logic              ack_tog_async,
    input  logic              snap_tog_async,
    input  logic [CNT_W:0]    snap_data,
    output logic              snap_ack_tog
);
    typedef struct packed {
        logic              req;
        logic              wc;
        logic              err;
        logic [1:0]        haddr;
        logic [CNT_W-1:0]  hdata;
        logic              ie;
        logic              re;
        logic [CNT_W-1:0]  load;
        logic              snap_seen;
        logic [CNT_W-1:0]  snap_val;
        logic              snap_pend;
        logic [DATA_W-1:0] rdata;
    } bus_st_t;

    bus_st_t d, q;
    logic ack_s, snap_s;
    logic [DATA_W-1:0] ctl_word;
    wire unused_wdata = ^wdata;

    wd_sync2 #(.W(1)) u_ack_sync  (.clk(clk), .rst_n(rst_n), .d(ack_tog_async),  .q(ack_s));
    wd_sync2 #(.W(1)) u_snap_sync (.clk(clk), .rst_n(rst_n), .d(snap_tog_async), .q(snap_s));

    always_comb begin
        ctl_word               = '0;
        ctl_word[CTL_WC_BIT]   = q.wc;
        ctl_word[CTL_ERR_BIT]  = q.err;
        ctl_word[CTL_PEND_BIT] = q.snap_pend;
        ctl_word[CTL_RE_BIT]   = q.re;
        ctl_word[CTL_IE_BIT]   = q.ie;
    end

    always_comb begin
        d = q;
        // acknowledge returned: the write has been applied in the counter domain
        if (!q.wc && (ack_s == q.req)) begin
            d.wc = 1'b1;
        end
        if (wr_en) begin
            if (q.wc) begin
                d.req   = ~q.req;
                d.wc    = 1'b0;
                d.err   = 1'b0;
                d.haddr = addr;
                d.hdata = wdata[CNT_W-1:0];
                case (wd_addr_e'(addr))
                    ADR_CTRL: begin
                        d.ie = wdata[CTL_IE_BIT];
                        d.re = wdata[CTL_RE_BIT];
                    end
                    ADR_LOAD: d.load = wdata[CNT_W-1:0];
                    default:  ;
                endcase
            end else begin
                d.err = 1'b1;
            end
        end
        // new snapshot from the counter domain; its data has been stable since the toggle
        if (snap_s != q.snap_seen) begin
            d.snap_seen = snap_s;
            d.snap_val  = snap_data[CNT_W-1:0];
            d.snap_pend = snap_data[CNT_W];
        end
        if (rd_en) begin
            case (wd_addr_e'(addr))
                ADR_CTRL:  d.rdata = ctl_word;
                ADR_LOAD:  d.rdata = DATA_W'(q.load);
                ADR_VALUE: d.rdata = DATA_W'(q.snap_val);
                default:   d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.wc        <= 1'b1;
            q.load      <= CNT_W'(RESET_LOAD);
            q.snap_val  <= CNT_W'(RESET_LOAD);
        end else begin
            q <= d;
        end
    end

    assign rdata        = q.rdata;
    assign req_tog      = q.req;
    assign hold_addr    = q.haddr;
    assign hold_data    = q.hdata;
    assign snap_ack_tog = q.snap_seen;

    // R2: an accepted write drops write-complete
    a_r2_accept_clears_wc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.wc) |=> !q.wc);

    // R3: write-complete rises only when the returned acknowledge matches the request
    a_r3_wc_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.wc) |-> $past(ack_s == q.req));

    // R4: a blocked write raises the error flag and leaves registers and request alone
    a_r4_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !q.wc) |=> (q.err && $stable(q.load) && $stable(q.req) && $stable(q.ie)));

    // R5: read data only moves on a read strobe
    a_r5_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(q.rdata));
endmodule

// File: rtl/wd_counter.sv
module wd_counter
    import xwd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int RESET_LOAD  = 65535,
    parameter int SNAP_PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tog_async,
    input  logic [1:0]       hold_addr,
    input  logic [CNT_W-1:0] hold_data,
    output logic             ack_tog,
    output logic             snap_tog,
    output logic [CNT_W:0]   snap_data,
    input  logic             snap_ack_async,
    output logic             irq,
    output logic             rst_req
);
    localparam int PER_W = (SNAP_PERIOD > 1) ? $clog2(SNAP_PERIOD) : 1;

    typedef struct packed {
        logic             req_seen;
        logic             ie;
        logic             re;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        logic             pend;
        logic             rreq;
        logic             stog;
        logic [CNT_W:0]   sdata;
        logic [PER_W-1:0] per;
        logic             force_snap;
    } wd_st_t;

    wd_st_t d, q;
    logic req_s, sack_s, apply, snap_busy;

    wd_sync2 #(.W(1)) u_req_sync  (.clk(clk), .rst_n(rst_n), .d(req_tog_async),  .q(req_s));
    wd_sync2 #(.W(1)) u_sack_sync (.clk(clk), .rst_n(rst_n), .d(snap_ack_async), .q(sack_s));

    assign apply     = (req_s != q.req_seen);
    assign snap_busy = (q.stog != sack_s);

    always_comb begin
        d = q;
        // count down, expire, escalate
        if (q.ie) begin
            if (q.count == '0) begin
                d.count = q.load;
                if (!q.pend) begin
                    d.pend = 1'b1;
                end else if (q.re) begin
                    d.rreq = 1'b1;
                end
            end else begin
                d.count = q.count - 1'b1;
            end
        end
        // snapshot toward the bus domain, one in flight at a time
        if (q.per != '0) begin
            d.per = q.per - 1'b1;
        end
        if (!snap_busy && ((q.per == '0) || q.force_snap)) begin
            d.sdata      = {q.pend, q.count};
            d.stog       = ~q.stog;
            d.per        = PER_W'(SNAP_PERIOD - 1);
            d.force_snap = 1'b0;
        end
        // apply a crossed write; hold registers are stable while the request is open
        if (apply) begin
            d.req_seen   = req_s;
            d.force_snap = 1'b1;
            case (wd_addr_e'(hold_addr))
                ADR_CTRL: begin
                    d.ie = hold_data[CTL_IE_BIT];
                    d.re = hold_data[CTL_RE_BIT];
                    if (hold_data[CTL_IE_BIT] && !q.ie) begin
                        d.count = q.load;
                    end
                end
                ADR_LOAD: begin
                    d.load  = hold_data;
                    d.count = hold_data;
                end
                ADR_ICLR: begin
                    d.pend  = 1'b0;
                    d.count = q.load;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.load  <= CNT_W'(RESET_LOAD);
            q.count <= CNT_W'(RESET_LOAD);
            q.sdata <= {1'b0, CNT_W'(RESET_LOAD)};
            q.per   <= PER_W'(SNAP_PERIOD - 1);
        end else begin
            q <= d;
        end
    end

    assign ack_tog   = q.req_seen;
    assign snap_tog  = q.stog;
    assign snap_data = q.sdata;
    assign irq       = q.pend;
    assign rst_req   = q.rreq;

    // R6: a disabled counter holds unless a write is being applied
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ie && !apply) |=> $stable(q.count));

    // R7: a reset request needs a pending interrupt and reset-enable one cycle earlier
    a_r7_escalate_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rreq) |-> ($past(q.pend) && $past(q.re)));

    // R7: the reset request is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.rreq |=> q.rreq);

    // R9: an applied interrupt clear drops pending
    a_r9_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && (hold_addr == ADR_ICLR)) |=> !q.pend);

    // R10: the snapshot data does not move while a snapshot is in flight
    a_r10_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_busy && $stable(q.stog)) |=> $stable(q.sdata));
endmodule

// File: rtl/xdom_wdog.sv
module xdom_wdog
    import xwd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int RESET_LOAD  = 65535,
    parameter int SNAP_PERIOD = 8
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wd_clk,
    input  logic              wd_rst_n,
    output logic              wd_irq,
    output logic              wd_rst_req
);
    logic             req_tog, ack_tog, snap_tog, snap_ack_tog;
    logic [1:0]       hold_addr;
    logic [CNT_W-1:0] hold_data;
    logic [CNT_W:0]   snap_data;

    wd_bus_if #(
        .CNT_W      (CNT_W),
        .RESET_LOAD (RESET_LOAD)
    ) u_bus (
        .clk            (bus_clk),
        .rst_n          (bus_rst_n),
        .addr           (bus_addr),
        .wr_en          (bus_wr_en),
        .wdata          (bus_wdata),
        .rd_en          (bus_rd_en),
        .rdata          (bus_rdata),
        .req_tog        (req_tog),
        .hold_addr      (hold_addr),
        .hold_data      (hold_data),
        .ack_tog_async  (ack_tog),
        .snap_tog_async (snap_tog),
        .snap_data      (snap_data),
        .snap_ack_tog   (snap_ack_tog)
    );

    wd_counter #(
        .CNT_W       (CNT_W),
        .RESET_LOAD  (RESET_LOAD),
        .SNAP_PERIOD (SNAP_PERIOD)
    ) u_cnt (
        .clk            (wd_clk),
        .rst_n          (wd_rst_n),
        .req_tog_async  (req_tog),
        .hold_addr      (hold_addr),
        .hold_data      (hold_data),
        .ack_tog        (ack_tog),
        .snap_tog       (snap_tog),
        .snap_data      (snap_data),
        .snap_ack_async (snap_ack_tog),
        .irq            (wd_irq),
        .rst_req        (wd_rst_req)
    );
endmodule

// File: tb/sim_xdom_wdog.sv
module sim_xdom_wdog;
    logic bclk = 1'b0, wclk = 1'b0;
    logic brst_n = 1'b0, wrst_n = 1'b0;
    always #4 bclk = ~bclk;     // 125 MHz bus clock
    always #11 wclk = ~wclk;    // unrelated counter clock

    logic [1:0]  addr  = 2'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        irq, rst_req;

    xdom_wdog u0 (
        .bus_clk(bclk), .bus_rst_n(brst_n), .bus_addr(addr), .bus_wr_en(wr_en),
        .bus_wdata(wdata), .bus_rd_en(rd_en), .bus_rdata(rdata),
        .wd_clk(wclk), .wd_rst_n(wrst_n), .wd_irq(irq), .wd_rst_req(rst_req)
    );

    int n_checks = 0, n_errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference of the counter-domain outputs, one comparison per counter clock
    bit m_on = 0, m_track = 0, m_seen = 0, m_re = 0;
    int m_cnt = 0, m_load = 0;
    always @(negedge wclk) begin
        if (wrst_n) begin
            if (!m_on) begin
                check(irq === 1'b0 && rst_req === 1'b0, "R6", "outputs while disabled",
                      {irq, rst_req}, 0);
            end else if (m_track) begin
                if (!m_seen) begin
                    if (irq) begin
                        m_seen = 1;
                        m_cnt = 0;
                    end
                end else begin
                    m_cnt++;
                end
                check(rst_req === (m_seen && m_re && (m_cnt >= m_load + 1)),
                      m_re ? "R7" : "R8", "reset request timing", rst_req,
                      (m_seen && m_re && (m_cnt >= m_load + 1)));
            end
        end
    end

    task automatic do_reset();
        m_on = 0; m_track = 0; m_seen = 0;
        brst_n = 1'b0; wrst_n = 1'b0;
        repeat (4) @(negedge wclk);
        brst_n = 1'b1; wrst_n = 1'b1;
        repeat (2) @(negedge bclk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge bclk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge bclk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge bclk);
        addr = a; rd_en = 1'b1;
        @(negedge bclk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_wc(input string req);
        logic [31:0] v;
        int polls = 0;
        v = '0;
        while (polls < 40) begin
            bus_read(2'd0, v);
            polls++;
            if (v[31]) break;
        end
        check(v[31] === 1'b1, req, "write-complete returns", v[31], 1);
    endtask

    task automatic wait_sig(input bit which_rst, output bit seen);
        seen = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge bclk);
            if ((which_rst ? rst_req : irq) === 1'b1) begin
                seen = 1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge bclk);
        n_errors++;
        $display("FAIL watchdog expired: run did not end");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v1, v2;
        bit seen;
        do_reset();

        // R1: reset state
        bus_read(2'd0, v);
        check(v === 32'h8000_0000, "R1", "control word after reset", v, 32'h8000_0000);
        check(irq === 1'b0 && rst_req === 1'b0, "R1", "outputs after reset", {irq, rst_req}, 0);

        // R6: counter holds at the reset load while disabled
        repeat (200) @(negedge bclk);
        bus_read(2'd2, v);
        check(v === 32'h0000_FFFF, "R6", "value held while disabled", v, 32'hFFFF);

        // R2 then R3
        bus_write(2'd1, 32'd20);
        bus_read(2'd0, v);
        check(v[31] === 1'b0, "R2", "write-complete low after write", v[31], 0);
        wait_wc("R3");

        // R4: second write lands while write-complete is low
        @(negedge bclk);
        addr = 2'd1; wdata = 32'd25; wr_en = 1'b1;
        @(negedge bclk);
        wdata = 32'd99;
        @(negedge bclk);
        wr_en = 1'b0;
        wait_wc("R4");
        bus_read(2'd1, v);
        check(v === 32'd25, "R4", "blocked write ignored", v, 25);
        bus_read(2'd0, v);
        check(v[30] === 1'b1, "R4", "error flag set", v[30], 1);

        // R11: load write reloads the disabled counter
        repeat (200) @(negedge bclk);
        bus_read(2'd2, v);
        check(v === 32'd25, "R11", "value after load write", v, 25);

        // R5: back-to-back reads
        @(negedge bclk);
        addr = 2'd1; rd_en = 1'b1;
        @(negedge bclk);
        v1 = rdata; addr = 2'd3;
        @(negedge bclk);
        v2 = rdata; addr = 2'd0;
        @(negedge bclk);
        rd_en = 1'b0; v = rdata;
        check(v1 === 32'd25, "R5", "first of consecutive reads", v1, 25);
        check(v2 === 32'd0, "R5", "clear address reads zero", v2, 0);
        check(v[31:30] === 2'b11, "R5", "third consecutive read", v[31:30], 3);

        // R7: enable with reset-enable; exact escalation interval from the model
        m_load = 25; m_re = 1;
        bus_write(2'd0, 32'h3);
        m_on = 1; m_track = 1;
        wait_wc("R7");
        bus_read(2'd0, v);
        check(v[30] === 1'b0 && v[1:0] === 2'b11, "R4", "error cleared, enables set", v, 32'h8000_0003);
        bus_read(2'd2, v);
        check(v <= 32'd25, "R10", "snapshot within load", v, 25);
        wait_sig(1'b1, seen);
        check(seen, "R7", "reset request raised", seen, 1);
        repeat (100) @(negedge bclk);
        bus_read(2'd0, v);
        check(v[2] === 1'b1, "R10", "pending bit visible", v[2], 1);
        check(rst_req === 1'b1, "R7", "reset request sticky", rst_req, 1);

        // R8: no escalation without reset-enable
        do_reset();
        m_load = 40; m_re = 0;
        bus_write(2'd1, 32'd40);
        wait_wc("R3");
        bus_write(2'd0, 32'h1);
        m_on = 1; m_track = 1;
        wait_wc("R8");
        repeat (1000) @(negedge bclk);
        check(irq === 1'b1 && rst_req === 1'b0, "R8", "irq pending, no reset", {irq, rst_req}, 2);

        // R9: clear drops pending
        m_track = 0;
        bus_write(2'd3, 32'd0);
        wait_wc("R9");
        check(irq === 1'b0, "R9", "irq cleared", irq, 0);

        // R9: periodic clears keep reset-enable from escalating
        bus_write(2'd0, 32'h3);
        wait_wc("R9");
        for (int k = 0; k < 4; k++) begin
            wait_sig(1'b0, seen);
            check(seen, "R9", "irq after reload", seen, 1);
            bus_write(2'd3, 32'd0);
            wait_wc("R9");
            check(irq === 1'b0 && rst_req === 1'b0, "R9", "cleared in time", {irq, rst_req}, 0);
        end

        // R7: escalation interval once clears stop
        m_re = 1; m_seen = 0; m_track = 1;
        wait_sig(1'b1, seen);
        check(seen, "R7", "reset request after unserviced expiries", seen, 1);
        repeat (20) @(negedge wclk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule